// File: doc/BRIEF.md
# Attribute-Driven Control Register Bank

A small memory-mapped bank of control and status words. Every bit carries an access attribute that is fixed when the design is elaborated. The attribute decides what a bus write does to that bit. The possible attributes are:

- **read-only:** the bit follows a hardware status input.
- **write-only:** stored, but reads back as zero.
- **read/write**
- **write-1-to-clear:** hardware sets the bit; software clears it.
- **write-once:** the first write access after reset takes effect and later writes are ignored.
- **write-lock-once:** free to change until the lock value is written, after which the bit is frozen.

Software reaches the bank through a simple synchronous port. The port has an address, a write strobe, write data with byte enables, a read strobe and registered read data. The stored value of every word is driven out on `ctrl_q` for the surrounding logic.

One address is split. A write there updates a write-only command word, while a read there returns a separate read-only status word. All attributes, reset defaults and lock values are parameters. The default map is:

| Address | Low byte | High byte |
|---|---|---|
| 0 | read/write | write-1-to-clear |
| 1 | write-once | lock-once |
| 2 (split) | write side: write-only command word | read side: read-only status word (stored as word 3) |
| 3 | unmapped | unmapped |

Top module: `attr_regbank`

## Requirements
- R1: Reset (`rst_n` low at a clock edge) loads each stored bit with its default. The defaults are: word 0 = 0x00A5, words 1 and 2 = 0x0000, status word = 0x0000. Reset also clears all write-once and lock state.
- R2: The read/write bits (word 0, bits 7:0) take the written value and read back unchanged.
- R3: A write changes only the bytes whose `bus_be` bit is 1. Bit 0 of `bus_be` covers data bits 7:0 and bit 1 covers bits 15:8. A write with `bus_be` = 0 changes nothing.
- R4: The read-only status word (`ctrl_q[63:48]`, read at address 2) holds the `hw_stat` value from the previous clock edge. Bus writes never alter it.
- R5: The write-1-to-clear bits (word 0, bits 15:8) behave as follows:
  - A 1 on the matching `hw_set` bit sets the bit.
  - Writing 1 clears the bit, and writing 0 leaves it unchanged.
  - When a set and a clear arrive in the same cycle, the bit ends up 1.
- R6: The write-once bits (word 1, bits 7:0) take the value of the first write access to their byte after reset, whatever that value is. Every later write is ignored.
- R7: The lock-once bits (word 1, bits 15:8) accept every write until a write stores the lock value (1 by default). From then on that bit is frozen until reset; each bit locks independently.
- R8: A write to address 2 updates the write-only command word (`ctrl_q[47:32]`). A read of address 2 returns the status word, never the command word.
- R9: At address 3, which is unmapped, reads return 0 and writes change no stored bit.
- R10: Read data appears on `bus_rdata` the cycle after `bus_rd` is high. It reflects the state before any write in that same cycle. `bus_rdata` is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for the write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| hw_set | input | 16 | Per-bit set requests for write-1-to-clear bits |
| hw_stat | input | 16 | Hardware status sampled by read-only bits |
| ctrl_q | output | 64 | Stored value of all four words, word n at bits 16n+15:16n |

## Verification
Each result has a fixed due time after its stimulus:
- A write is visible on `ctrl_q` one edge after it is presented.
- A `hw_set` pulse or a `hw_stat` value likewise lands one edge later.
- Read data for a read presented before edge k is due on `bus_rdata` just after edge k. It carries the pre-write state if a write shares that cycle.

The bench drives every input just after a falling edge and advances its behavioural model at the rising edge from those same inputs. It then compares `bus_rdata` and `ctrl_q` at the next falling edge, so every expectation is sampled exactly one register stage after its cause. Directed checks with fixed constants add to the per-cycle comparison for each corner case.

// File: rtl/regbank_pkg.sv
// Shared access attribute codes for the register bank.
package regbank_pkg;
    typedef enum logic [2:0] {
        ACC_RO   = 3'd0,
        ACC_WO   = 3'd1,
        ACC_RW   = 3'd2,
        ACC_W1C  = 3'd3,
        ACC_ONCE = 3'd4,
        ACC_LOCK = 3'd5
    } acc_t;
endpackage

// File: rtl/rb_bit_cell.sv
// One storage bit whose write behaviour is chosen by ATTR.
// Assumes wr_en is already qualified by address and byte enable.
module rb_bit_cell
    import regbank_pkg::*;
#(
    parameter logic [2:0] ATTR     = ACC_RW,
    parameter logic       RST_VAL  = 1'b0,
    parameter logic       LOCK_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic hw_set,
    input  logic hw_val,
    output logic q,
    output logic rd_val
);
    logic frozen;

    // Update the bit according to its attribute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= RST_VAL;
            frozen <= 1'b0;
        end else begin
            case (ATTR)
                ACC_RO:         q <= hw_val;
                ACC_WO, ACC_RW: if (wr_en) q <= wr_bit;
                ACC_W1C: begin
                    if (hw_set)                q <= 1'b1;
                    else if (wr_en && wr_bit)  q <= 1'b0;
                end
                ACC_ONCE: begin
                    if (wr_en && !frozen) begin
                        q      <= wr_bit;
                        frozen <= 1'b1;
                    end
                end
                ACC_LOCK: begin
                    if (wr_en && !frozen) begin
                        q      <= wr_bit;
                        frozen <= (wr_bit == LOCK_VAL);
                    end
                end
                default: q <= q;
            endcase
        end
    end

    // Write-only bits read back as zero.
    assign rd_val = (ATTR == ACC_WO) ? 1'b0 : q;

    generate
        if (ATTR == ACC_RO) begin : g_ro_chk
            AST_RO_TRACKS_HW: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> q == $past(hw_val)); // R4
        end
        if (ATTR == ACC_W1C) begin : g_w1c_chk
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                hw_set |=> q); // R5
            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_bit && !hw_set) |=> !q); // R5
        end
        if (ATTR == ACC_ONCE) begin : g_once_chk
            AST_ONCE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !frozen) |=> q == $past(wr_bit)); // R6
            AST_ONCE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                frozen |=> $stable(q)); // R6
        end
        if (ATTR == ACC_LOCK) begin : g_lock_chk
            AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                frozen |=> $stable(q)); // R7
            AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !frozen) |=> q == $past(wr_bit)); // R7
        end
    endgenerate
endmodule

// File: rtl/rb_reg_word.sv
// One register word built from per-bit cells; byte enables gate writes.
// Assumes DATA_W is a multiple of 8.
module rb_reg_word #(
    parameter int                    DATA_W = 16,
    parameter logic [DATA_W*3-1:0]   ATTRS  = '0,
    parameter logic [DATA_W-1:0]     RSTS   = '0,
    parameter logic [DATA_W-1:0]     LOCKS  = '1,
    localparam int                   NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    input  logic [DATA_W-1:0] hw_val,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] rd_val
);
    generate
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            rb_bit_cell #(
                .ATTR     (ATTRS[b*3 +: 3]),
                .RST_VAL  (RSTS[b]),
                .LOCK_VAL (LOCKS[b])
            ) i_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_be[b/8]),
                .wr_bit (wdata[b]),
                .hw_set (hw_set[b]),
                .hw_val (hw_val[b]),
                .q      (q[b]),
                .rd_val (rd_val[b])
            );
        end
    endgenerate
endmodule

// File: rtl/rb_read_path.sv
// Registered read mux: selects a word by address, redirects the split
// address to its shadow word, returns zero for unmapped or idle cycles.
module rb_read_path #(
    parameter int DATA_W       = 16,
    parameter int NUM_WORDS    = 4,
    parameter int ADDR_W       = 2,
    parameter int MAPPED_ADDRS = 3,
    parameter int SPLIT_ADDR   = 2,
    parameter int SHADOW_IDX   = 3,
    localparam int IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   rd_addr,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0]    words,
    output logic [DATA_W-1:0]                   rdata
);
    logic [IDX_W-1:0] sel_idx;
    logic             hit;

    // Decode the address into a word index and a mapped flag.
    always_comb begin
        sel_idx = (rd_addr == ADDR_W'(SPLIT_ADDR)) ? IDX_W'(SHADOW_IDX) : IDX_W'(rd_addr);
        hit     = (32'(rd_addr) < MAPPED_ADDRS);
    end

    // Capture the selected word one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)              rdata <= '0;
        else if (rd_en && hit)   rdata <= words[sel_idx];
        else                     rdata <= '0;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0); // R10
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && 32'(rd_addr) >= MAPPED_ADDRS) |=> rdata == '0); // R9
endmodule

// File: rtl/attr_regbank.sv
// Register bank top: write decode per word, word storage, registered read.
// Assumes one bus access per cycle; address SPLIT_ADDR writes its own word
// and reads word SHADOW_IDX, which no address can write.
module attr_regbank
    import regbank_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int NUM_WORDS    = 4,
    parameter int ADDR_W       = 2,
    parameter int MAPPED_ADDRS = 3,
    parameter int SPLIT_ADDR   = 2,
    parameter int SHADOW_IDX   = 3,
    parameter logic [NUM_WORDS*DATA_W*3-1:0] ATTR_MAP = {
        {16{ACC_RO}}, {16{ACC_WO}},
        {8{ACC_LOCK}}, {8{ACC_ONCE}},
        {8{ACC_W1C}}, {8{ACC_RW}}},
    parameter logic [NUM_WORDS*DATA_W-1:0] RESET_MAP = 64'h0000_0000_0000_00A5,
    parameter logic [NUM_WORDS*DATA_W-1:0] LOCK_MAP  = '1,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic [NBYTES-1:0]             bus_be,
    input  logic                          bus_rd,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [DATA_W-1:0]             hw_set,
    input  logic [DATA_W-1:0]             hw_stat,
    output logic [NUM_WORDS*DATA_W-1:0]   ctrl_q
);
    logic [NUM_WORDS-1:0][NBYTES-1:0] word_be;
    logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
    logic [NUM_WORDS-1:0][DATA_W-1:0] word_rd;

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            if (w < MAPPED_ADDRS) begin : g_wr
                // Route byte enables to the addressed word only.
                assign word_be[w] = (bus_wr && bus_addr == ADDR_W'(w)) ? bus_be : '0;
            end else begin : g_nowr
                assign word_be[w] = '0;
            end
            rb_reg_word #(
                .DATA_W (DATA_W),
                .ATTRS  (ATTR_MAP[w*DATA_W*3 +: DATA_W*3]),
                .RSTS   (RESET_MAP[w*DATA_W +: DATA_W]),
                .LOCKS  (LOCK_MAP[w*DATA_W +: DATA_W])
            ) i_word (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_be  (word_be[w]),
                .wdata  (bus_wdata),
                .hw_set (hw_set),
                .hw_val (hw_stat),
                .q      (word_q[w]),
                .rd_val (word_rd[w])
            );
        end
    endgenerate

    rb_read_path #(
        .DATA_W       (DATA_W),
        .NUM_WORDS    (NUM_WORDS),
        .ADDR_W       (ADDR_W),
        .MAPPED_ADDRS (MAPPED_ADDRS),
        .SPLIT_ADDR   (SPLIT_ADDR),
        .SHADOW_IDX   (SHADOW_IDX)
    ) i_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (bus_rd),
        .rd_addr (bus_addr),
        .words   (word_rd),
        .rdata   (bus_rdata)
    );

    assign ctrl_q = word_q;

    AST_UNMAPPED_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && 32'(bus_addr) >= MAPPED_ADDRS) |=> $stable(word_q[MAPPED_ADDRS-1:1])); // R9
    AST_SPLIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(SPLIT_ADDR) && bus_be == '1)
        |=> word_q[SPLIT_ADDR] == $past(bus_wdata)); // R8
endmodule

// File: tb/test_attr_regbank.sv
`timescale 1ns/1ps
module test_attr_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] hw_set = '0;
    logic [15:0] hw_stat = '0;
    logic [63:0] ctrl_q;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;
    string phase = "R1";

    // reference model state
    bit          m_q[4][16];
    bit          m_done[4][16];
    logic [15:0] m_rdata;

    always #2 clk = ~clk;

    attr_regbank i_attr_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .hw_set(hw_set), .hw_stat(hw_stat),
        .ctrl_q(ctrl_q)
    );

    // attribute codes: 0 RO, 1 WO, 2 RW, 3 W1C, 4 once, 5 lock
    function automatic int battr(int w, int b);
        case (w)
            0: return (b < 8) ? 2 : 3;
            1: return (b < 8) ? 4 : 5;
            2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] m_ctrl();
        logic [63:0] v;
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 16; b++) v[w*16+b] = m_q[w][b];
        return v;
    endfunction

    task automatic model_edge();
        logic [15:0] nxt_rd;
        nxt_rd = '0;
        if (!rst_n) begin
            for (int w = 0; w < 4; w++)
                for (int b = 0; b < 16; b++) begin
                    m_q[w][b] = (w == 0) ? bit'((16'h00A5 >> b) & 1) : 1'b0;
                    m_done[w][b] = 1'b0;
                end
            m_rdata = '0;
            return;
        end
        if (bus_rd && bus_addr != 2'd3) begin
            int idx = (bus_addr == 2'd2) ? 3 : int'(bus_addr);
            for (int b = 0; b < 16; b++)
                nxt_rd[b] = (battr(idx, b) == 1) ? 1'b0 : m_q[idx][b];
        end
        for (int w = 0; w < 4; w++)
            for (int b = 0; b < 16; b++) begin
                bit we = bus_wr && bus_addr != 2'd3 && int'(bus_addr) == w && bus_be[b/8];
                bit d = bus_wdata[b];
                case (battr(w, b))
                    0: m_q[w][b] = hw_stat[b];
                    1, 2: if (we) m_q[w][b] = d;
                    3: if (hw_set[b]) m_q[w][b] = 1'b1; else if (we && d) m_q[w][b] = 1'b0;
                    4: if (we && !m_done[w][b]) begin m_q[w][b] = d; m_done[w][b] = 1'b1; end
                    default: if (we && !m_done[w][b]) begin m_q[w][b] = d; m_done[w][b] = d; end
                endcase
            end
        m_rdata = nxt_rd;
    endtask

    task automatic chk16(string req, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk64(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: model advances at the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk16(phase, "model rdata", bus_rdata, m_rdata);
        chk64(phase, "model ctrl_q", ctrl_q, m_ctrl());
    endtask

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0; bus_be = '0;
    endtask

    task automatic do_wr(logic [1:0] a, logic [15:0] d, logic [1:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1; bus_rd = 1'b0;
        step();
        idle();
    endtask

    task automatic do_rd(logic [1:0] a, logic [15:0] exp, string req);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        step();
        chk16(req, "directed rdata", bus_rdata, exp);
        idle();
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        logic [63:0] saved;
        @(negedge clk);
        phase = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk64("R1", "reset ctrl_q", ctrl_q, 64'h0000_0000_0000_00A5);
        do_rd(2'd0, 16'h00A5, "R1");

        phase = "R2";
        do_wr(2'd0, 16'h5A3C, 2'b01);
        do_rd(2'd0, 16'h003C, "R2");

        phase = "R3";
        do_wr(2'd0, 16'hFFFF, 2'b00);
        do_rd(2'd0, 16'h003C, "R3");

        phase = "R5";
        hw_set = 16'h0300;
        step();
        hw_set = '0;
        do_rd(2'd0, 16'h033C, "R5");
        do_wr(2'd0, 16'h0100, 2'b10);
        do_rd(2'd0, 16'h023C, "R5");
        do_wr(2'd0, 16'h0000, 2'b11);
        do_rd(2'd0, 16'h0200, "R5");
        hw_set = 16'h0400;
        do_wr(2'd0, 16'h0400, 2'b10);
        hw_set = '0;
        do_rd(2'd0, 16'h0600, "R5");

        phase = "R6";
        do_wr(2'd1, 16'h005A, 2'b01);
        do_wr(2'd1, 16'h00FF, 2'b01);
        do_rd(2'd1, 16'h005A, "R6");

        phase = "R7";
        do_wr(2'd1, 16'h0000, 2'b10);
        do_wr(2'd1, 16'hF000, 2'b10);
        do_wr(2'd1, 16'h0500, 2'b10);
        do_rd(2'd1, 16'hF55A, "R7");
        do_wr(2'd1, 16'h0000, 2'b10);
        do_rd(2'd1, 16'hF55A, "R7");
        do_wr(2'd1, 16'h0A00, 2'b10);
        do_rd(2'd1, 16'hFF5A, "R7");

        phase = "R8";
        hw_stat = 16'hBEEF;
        do_wr(2'd2, 16'h1234, 2'b11);
        chk16("R8", "command word", ctrl_q[47:32], 16'h1234);
        chk16("R4", "status word", ctrl_q[63:48], 16'hBEEF);
        do_rd(2'd2, 16'hBEEF, "R8");
        phase = "R4";
        do_wr(2'd2, 16'hFFFF, 2'b11);
        do_rd(2'd2, 16'hBEEF, "R4");

        phase = "R9";
        saved = ctrl_q;
        do_wr(2'd3, 16'hFFFF, 2'b11);
        chk64("R9", "unmapped write", ctrl_q, saved);
        do_rd(2'd3, 16'h0000, "R9");

        phase = "R10";
        bus_addr = 2'd0; bus_wdata = 16'h00AA; bus_be = 2'b01;
        bus_wr = 1'b1; bus_rd = 1'b1;
        step();
        chk16("R10", "read beside write", bus_rdata, 16'h0600);
        idle();
        step();
        chk16("R10", "idle rdata", bus_rdata, 16'h0000);
        do_rd(2'd0, 16'h06AA, "R10");

        phase = "R10 mixed";
        for (int i = 0; i < 400; i++) begin
            bus_addr  = 2'($urandom % 4);
            bus_wr    = 1'($urandom % 2);
            bus_rd    = 1'($urandom % 2);
            bus_wdata = 16'($urandom);
            bus_be    = 2'($urandom % 4);
            hw_set    = (($urandom % 4) == 0) ? 16'($urandom) : 16'h0000;
            hw_stat   = 16'($urandom);
            rst_n     = (($urandom % 97) != 0);
            step();
        end
        idle();
        hw_set = '0;

        phase = "R1";
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        do_rd(2'd0, 16'h00A5, "R1");
        phase = "R6";
        do_wr(2'd1, 16'h0033, 2'b01);
        do_rd(2'd1, 16'h0033, "R6");

        finish_run();
    end
endmodule